// File: doc/BRIEF.md
# Carry-Select Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. It takes two operands, a carry input and a 3-bit operation code, and returns a result word with three status flags: carry out, zero and signed overflow. It covers add with carry, subtract, and the bitwise AND, OR and XOR operations.

The adder is split at bit 16. The lower half is a plain ripple chain fed by the carry input. The upper half is built twice, once assuming a carry of 0 and once assuming a carry of 1, so both copies work in parallel with the lower half. When the lower carry settles, it picks one upper sum and its carries. Subtraction feeds the inverted second operand into the same adder with the carry forced to 1.

Top module: `alu_csel`

## Requirements
- R1: Op code 000 (add) gives result = (A + B + cin) mod 2^32, and carry out is bit 32 of that sum.
- R2: Op code 001 (subtract) gives result = (A - B) mod 2^32 and ignores cin; carry out is 1 exactly when A >= B as unsigned numbers.
- R3: Op codes 010, 011 and 100 give the bitwise AND, OR and XOR of A and B.
- R4: Op codes 101, 110 and 111 give a result of 0, carry out 0 and overflow 0.
- R5: The zero flag is 1 exactly when all 32 result bits are 0, under every op code.
- R6: For add and subtract, overflow is 1 exactly when the two's-complement result does not fit in 32 bits. An add whose operands have opposite sign bits never overflows.
- R7: For the three bitwise op codes, carry out and overflow are both 0.
- R8: A carry out of bit 15 reaches the upper half correctly. Examples are 0x0000FFFF + 1, and all-ones plus zero with cin = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry input, used by add only |
| op_i | input | 3 | Operation code |
| res_o | output | 32 | Result word |
| cout_o | output | 1 | Carry out of bit 31 |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow for add and subtract |

## Verification
The assertions are immediate and sit inside combinational blocks, so they assume the operands and op code are fully known, 2-state values whenever the block is evaluated. The bench drives every input from the start of the run and changes them only on the rising clock edge. It reads the outputs half a period later, by which time all inputs are stable. The stimulus covers all eight op codes, including the three unused ones, and includes carry chains that cross the split at bit 16.

// File: rtl/alu_csel_pkg.sv
package alu_csel_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } alu_op_e;

  // Bitwise part of the unit; unused codes fold to zero.
  function automatic logic [31:0] bitwise_fn(input logic [2:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic is_bitwise(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/alu_rca_seg.sv
module alu_rca_seg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[W];
  assign cmsb_o = c[W-1];
endmodule

// File: rtl/alu_csel_adder.sv
module alu_csel_adder #(
  parameter int WIDTH = 32,
  parameter int SPLIT = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cmsb_o
);
  localparam int HI = WIDTH - SPLIT;

  logic [SPLIT-1:0] lo_sum;
  logic             lo_cout;
  logic             lo_cmsb;
  logic [HI-1:0]    hi_sum  [2];
  logic             hi_cout [2];
  logic             hi_cmsb [2];

  alu_rca_seg #(.W(SPLIT)) u_lo (
    .a_i   (a_i[SPLIT-1:0]),
    .b_i   (b_i[SPLIT-1:0]),
    .cin_i (cin_i),
    .sum_o (lo_sum),
    .cout_o(lo_cout),
    .cmsb_o(lo_cmsb)
  );

  // Upper half evaluated speculatively for both incoming carries.
  for (genvar k = 0; k < 2; k++) begin : g_hi
    alu_rca_seg #(.W(HI)) u_hi (
      .a_i   (a_i[WIDTH-1:SPLIT]),
      .b_i   (b_i[WIDTH-1:SPLIT]),
      .cin_i (k[0]),
      .sum_o (hi_sum[k]),
      .cout_o(hi_cout[k]),
      .cmsb_o(hi_cmsb[k])
    );
  end

  assign sum_o  = {hi_sum[lo_cout], lo_sum};
  assign cout_o = hi_cout[lo_cout];
  assign cmsb_o = hi_cmsb[lo_cout];

  always_comb begin
    // R8: the lower carry out is the majority of the top lower bit's inputs
    p_lo_carry_r8: assert (lo_cout ==
        ((a_i[SPLIT-1] & b_i[SPLIT-1]) | (lo_cmsb & (a_i[SPLIT-1] ^ b_i[SPLIT-1]))))
      else $error("lower half carry inconsistent");
    // R1: selected sum and carry match a full-width sum
    p_sum_match_r1: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("carry-select sum mismatch");
  end
endmodule

// File: rtl/alu_csel.sv
module alu_csel
  import alu_csel_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SPLIT = 16
) (
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic        cin_i,
  input  logic [2:0]  op_i,
  output logic [31:0] res_o,
  output logic        cout_o,
  output logic        zero_o,
  output logic        ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic             do_sub;
  logic             do_arith;
  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_cmsb;
  logic [WIDTH-1:0] bit_res;

  assign do_sub   = (op_i == OP_SUB);
  assign do_arith = is_arith(op_i);
  assign b_eff    = do_sub ? ~b_i : b_i;
  assign c_eff    = do_sub ? 1'b1 : cin_i;

  alu_csel_adder #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_add (
    .a_i   (a_i),
    .b_i   (b_eff),
    .cin_i (c_eff),
    .sum_o (add_sum),
    .cout_o(add_cout),
    .cmsb_o(add_cmsb)
  );

  assign bit_res = bitwise_fn(op_i, a_i, b_i);

  assign res_o  = do_arith ? add_sum : bit_res;
  assign cout_o = do_arith & add_cout;
  assign ovf_o  = do_arith & (add_cmsb ^ add_cout);
  assign zero_o = ~|res_o;

  always_comb begin
    // R6: opposite-sign add never overflows
    p_no_overflow_r6: assert (!((op_i == OP_ADD) && (a_i[MSB] != b_i[MSB]) && ovf_o))
      else $error("overflow on opposite-sign add");
    // R7: bitwise ops leave carry and overflow clear
    p_bitwise_flags_r7: assert (!(is_bitwise(op_i) && (cout_o || ovf_o)))
      else $error("flag set on bitwise op");
    // R4: unused codes give an all-zero result with zero flag set
    p_unused_zero_r4: assert (!((op_i > 3'b100) && (!zero_o || cout_o || ovf_o)))
      else $error("unused code not quiet");
    // R2: equal operands subtract to zero with carry out set
    p_sub_equal_r2: assert (!(do_sub && (a_i == b_i) && !(zero_o && cout_o)))
      else $error("A-A not zero");
  end
endmodule

// File: tb/alu_csel_test.sv
module alu_csel_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic        cin;
  logic [2:0]  op;
  logic [31:0] res;
  logic        cout, zero, ovf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_csel uut (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(op),
    .res_o(res), .cout_o(cout), .zero_o(zero), .ovf_o(ovf)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply on the rising edge, compare at the falling edge.
  task automatic run(input string tag, input logic [2:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic c);
    logic [31:0] er;
    logic        ec, ev;
    logic [32:0] s;
    @(posedge clk);
    op = o; a = x; b = y; cin = c;
    er = '0; ec = 1'b0; ev = 1'b0;
    case (o)
      3'b000: begin
        s  = {1'b0, x} + {1'b0, y} + {32'b0, c};
        er = s[31:0]; ec = s[32];
        ev = (x[31] == y[31]) && (er[31] != x[31]);
      end
      3'b001: begin
        er = x - y; ec = (x >= y);
        ev = (x[31] != y[31]) && (er[31] != x[31]);
      end
      3'b010: er = x & y;
      3'b011: er = x | y;
      3'b100: er = x ^ y;
      default: er = '0;
    endcase
    @(negedge clk);
    check({tag, " result"}, res, er);
    check({tag, " carry"}, {31'b0, cout}, {31'b0, ec});
    check({tag, " zero R5"}, {31'b0, zero}, {31'b0, er == 32'b0});
    check({tag, " ovf"}, {31'b0, ovf}, {31'b0, ev});
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R5 initial zero", {31'b0, zero}, 32'd1);
  endtask

  task automatic t_add();
    run("R1 add small", 3'b000, 32'd5, 32'd7, 1'b0);
    run("R1 add cin", 3'b000, 32'd5, 32'd7, 1'b1);
    run("R1 add wrap", 3'b000, 32'hFFFF_FFFF, 32'd2, 1'b0);
    run("R6 add pos ovf", 3'b000, 32'h7FFF_FFFF, 32'd1, 1'b0);
    run("R6 add neg ovf", 3'b000, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run("R6 add opposite", 3'b000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_sub();
    run("R2 sub equal", 3'b001, 32'h1234_5678, 32'h1234_5678, 1'b0);
    run("R2 sub cin ignored", 3'b001, 32'd10, 32'd3, 1'b1);
    run("R2 sub borrow", 3'b001, 32'd3, 32'd10, 1'b0);
    run("R6 sub ovf", 3'b001, 32'h8000_0000, 32'd1, 1'b0);
    run("R6 sub ovf2", 3'b001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_logic();
    run("R3 R7 and", 3'b010, 32'hF0F0_FFFF, 32'hFFFF_0F0F, 1'b1);
    run("R3 R7 or", 3'b011, 32'h8000_0001, 32'h0000_FF00, 1'b1);
    run("R3 R7 xor", 3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run("R3 R7 xor b", 3'b100, 32'hA5A5_0000, 32'h0F0F_FFFF, 1'b0);
  endtask

  task automatic t_unused();
    for (int k = 5; k < 8; k++)
      run("R4 unused", 3'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_split();
    run("R8 split carry", 3'b000, 32'h0000_FFFF, 32'd1, 1'b0);
    run("R8 all ones cin", 3'b000, 32'hFFFF_FFFF, 32'd0, 1'b1);
    run("R8 no split carry", 3'b000, 32'h0000_7FFF, 32'h0000_8000, 1'b0);
    run("R8 sub across", 3'b001, 32'h0001_0000, 32'd1, 1'b0);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 200; i++)
      run("R1 R2 R3 mixed", 3'($urandom_range(0, 7)), $urandom, $urandom, 1'($urandom));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; op = 3'b000;
    t_reset_state();
    t_add();
    t_sub();
    t_logic();
    t_unused();
    t_split();
    t_mixed();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule